// File: doc/BRIEF.md
# Bipolar Line Carrier Monitor

This block sits behind the rail inputs of an alternate-mark-inversion T1 receiver. For every received bit it merges the positive and negative rails into one NRZ data bit. It flags loss of carrier once a long run of zero bits has been seen, and it flags each mark whose polarity repeats the polarity of the mark before it. Each such violation advances a saturating error counter, which the host can preset at any time.

The receive clock domain provides a bit strobe, `bit_en`. The rails are sampled only on clock edges where that strobe is high. This models the sampling edge of the line clock inside a faster system clock. A line interface that feeds the same NRZ signal to both rails raises both rails on each mark. The block detects this and stops checking polarity for as long as that wiring is in use. It also reports the condition on `nrz_mode`. The asynchronous active-low reset is released through a two-stage synchronizer, so the block starts sampling on the third clock edge after `rst_n` goes high.

Top module: `bipolar_line_monitor`

## Requirements
- R1: While reset is asserted, all outputs are 0, including `bpv_count`.
- R2: The rails are sampled only on clock edges where `bit_en` is 1. On other edges every output keeps its value, whatever the rails carry, except `bpv_count`, which still responds to a preset.
- R3: After each sampled bit, `nrz_data` equals the OR of the two rails for that bit.
- R4: `carrier_lost` goes to 1 on the sampled bit that completes LOSS_ZEROS (default 32) consecutive bits with both rails at 0. It is still 0 after LOSS_ZEROS-1 such bits, and it stays at 1 while zeros continue.
- R5: `carrier_lost` returns to 0 on the first sampled bit that has either rail at 1.
- R6: A single-rail mark (`rail_p`=1 means positive, `rail_n`=1 means negative) whose polarity equals that of the previous reference mark drives `bpv_flag` to 1 for that bit. Any later sampled bit that is not a violation drives it back to 0.
- R7: The first single-rail mark after reset only sets the reference polarity and never raises `bpv_flag`. The same holds for the first single-rail mark after a both-rails-high bit.
- R8: Each violation increments `bpv_count` by one, on the same edge that raises `bpv_flag`.
- R9: `bpv_count` saturates at 255 and never wraps to 0.
- R10: `preset_en`=1 loads `preset_val` into `bpv_count` on that edge, whether or not `bit_en` is high. The preset wins over a violation counted on the same edge.
- R11: A sampled bit with both rails at 1 sets `nrz_mode`, never raises `bpv_flag`, and clears the reference polarity. The next single-rail mark clears `nrz_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit strobe: sample the rails on this edge |
| rail_p | input | 1 | Positive-pulse rail |
| rail_n | input | 1 | Negative-pulse rail |
| preset_en | input | 1 | Load `preset_val` into the violation counter |
| preset_val | input | 8 | Counter preset value |
| nrz_data | output | 1 | Merged NRZ data of the last sampled bit |
| nrz_mode | output | 1 | Tied-rail (NRZ) input detected; polarity checking suspended |
| carrier_lost | output | 1 | Run of LOSS_ZEROS zero bits seen and no mark since |
| bpv_flag | output | 1 | The last sampled bit was a bipolar violation |
| bpv_count | output | 8 | Saturating violation counter |

## Verification
The bench drives a zero run of exactly 31 bits and then one more. A detector with an off-by-one in its run length would raise carrier loss a bit early or a bit late. It walks marks of the same and alternating polarity, starting from a fresh reference. A design that compared the first mark against a stale reset polarity would count a false violation there. It presets the counter near its top and keeps injecting violations, which exposes a counter that wraps to zero. It also presets on the same edge as a violation, where a design with the wrong priority would show the preset value plus one. Between bits it drives both rails high with the strobe low, and any sampling outside the strobe would then show up as a spurious `nrz_mode` or data change.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  typedef enum logic {
    POL_NEG = 1'b0,
    POL_POS = 1'b1
  } pol_e;

  localparam int unsigned CNT_W_DEF      = 8;
  localparam int unsigned LOSS_ZEROS_DEF = 32;
endpackage

// File: rtl/bpm_zero_run.sv
module bpm_zero_run #(
  parameter int unsigned LOSS_ZEROS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic mark,
  output logic carrier_lost
);
  localparam int unsigned RUN_W = $clog2(LOSS_ZEROS + 1);
  localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(LOSS_ZEROS);

  logic [RUN_W-1:0] run_q, run_d;
  logic             lost_q, lost_d;

  always_comb begin
    run_d  = run_q;
    lost_d = lost_q;
    if (bit_en) begin
      if (mark) begin
        run_d  = '0;
        lost_d = 1'b0;
      end else begin
        if (run_q != RUN_LIMIT) run_d = run_q + 1'b1;
        if (run_d == RUN_LIMIT) lost_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      lost_q <= lost_d;
    end
  end

  assign carrier_lost = lost_q;

  assert_clear_on_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mark) |=> !carrier_lost);

  assert_set_at_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_lost) |-> (run_q == RUN_LIMIT));

endmodule

// File: rtl/bpm_polarity.sv
module bpm_polarity
  import bpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rail_p,
  input  logic rail_n,
  output logic nrz_data,
  output logic nrz_mode,
  output logic bpv_flag,
  output logic bpv_event
);
  logic have_ref_q, have_ref_d;
  pol_e pol_q, pol_d, cur_pol;
  logic nrz_q, nrz_d;
  logic mode_q, mode_d;
  logic bpv_q, bpv_d;
  logic viol;

  always_comb begin
    have_ref_d = have_ref_q;
    pol_d      = pol_q;
    nrz_d      = nrz_q;
    mode_d     = mode_q;
    bpv_d      = bpv_q;
    viol       = 1'b0;
    cur_pol    = rail_p ? POL_POS : POL_NEG;
    if (bit_en) begin
      nrz_d = rail_p | rail_n;
      bpv_d = 1'b0;
      if (rail_p && rail_n) begin
        mode_d     = 1'b1;
        have_ref_d = 1'b0;
      end else if (rail_p || rail_n) begin
        viol       = have_ref_q && (cur_pol == pol_q);
        bpv_d      = viol;
        mode_d     = 1'b0;
        have_ref_d = 1'b1;
        pol_d      = cur_pol;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_ref_q <= 1'b0;
      pol_q      <= POL_NEG;
      nrz_q      <= 1'b0;
      mode_q     <= 1'b0;
      bpv_q      <= 1'b0;
    end else begin
      have_ref_q <= have_ref_d;
      pol_q      <= pol_d;
      nrz_q      <= nrz_d;
      mode_q     <= mode_d;
      bpv_q      <= bpv_d;
    end
  end

  assign nrz_data  = nrz_q;
  assign nrz_mode  = mode_q;
  assign bpv_flag  = bpv_q;
  assign bpv_event = viol;

  assert_tied_no_bpv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && rail_p && rail_n) |=> (!bpv_flag && nrz_mode));

  assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(bpv_flag) && $stable(nrz_data) && $stable(nrz_mode)));

  assert_idle_bit_no_bpv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !rail_p && !rail_n) |=> !bpv_flag);

endmodule

// File: rtl/bpm_err_counter.sv
module bpm_err_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             preset_en,
  input  logic [CNT_W-1:0] preset_val,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (preset_en)                    cnt_d = preset_val;
    else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_en && count == CNT_MAX) |=> (count == CNT_MAX));

  assert_step_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !preset_en && count != CNT_MAX) |=> (count == CNT_W'($past(count) + 1'b1)));

  assert_preset_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    preset_en |=> (count == $past(preset_val)));

endmodule

// File: rtl/bipolar_line_monitor.sv
module bipolar_line_monitor #(
  parameter int unsigned LOSS_ZEROS = bpm_pkg::LOSS_ZEROS_DEF,
  parameter int unsigned CNT_W      = bpm_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rail_p,
  input  logic             rail_n,
  input  logic             preset_en,
  input  logic [CNT_W-1:0] preset_val,
  output logic             nrz_data,
  output logic             nrz_mode,
  output logic             carrier_lost,
  output logic             bpv_flag,
  output logic [CNT_W-1:0] bpv_count
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       bpv_event;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  bpm_zero_run #(.LOSS_ZEROS(LOSS_ZEROS)) u_zero_run (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .bit_en       (bit_en),
    .mark         (rail_p | rail_n),
    .carrier_lost (carrier_lost)
  );

  bpm_polarity u_polarity (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bit_en    (bit_en),
    .rail_p    (rail_p),
    .rail_n    (rail_n),
    .nrz_data  (nrz_data),
    .nrz_mode  (nrz_mode),
    .bpv_flag  (bpv_flag),
    .bpv_event (bpv_event)
  );

  bpm_err_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .inc        (bpv_event),
    .preset_en  (preset_en),
    .preset_val (preset_val),
    .count      (bpv_count)
  );

  assert_flag_counts_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(bpv_flag) && !$past(preset_en) && $past(bpv_count) != '1)
      |-> (bpv_count != $past(bpv_count)));

endmodule

// File: tb/bipolar_line_monitor_tb.sv
`timescale 1ns/1ps
module bipolar_line_monitor_tb;
  typedef struct {
    logic       nrz;
    logic       nrzm;
    logic       cl;
    logic       bpv;
    logic [7:0] cnt;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, rail_p = 1'b0, rail_n = 1'b0, preset_en = 1'b0;
  logic [7:0] preset_val = 8'd0;
  logic       nrz_data, nrz_mode, carrier_lost, bpv_flag;
  logic [7:0] bpv_count;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  exp_t exp_q[$];

  // bench model state
  int   m_zr = 0, m_cnt = 0;
  logic m_ref = 1'b0, m_pol = 1'b0, m_cl = 1'b0, m_nrzm = 1'b0, m_bpv = 1'b0, m_nrz = 1'b0;

  always #2 clk = ~clk;

  bipolar_line_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rail_p(rail_p), .rail_n(rail_n),
    .preset_en(preset_en), .preset_val(preset_val), .nrz_data(nrz_data),
    .nrz_mode(nrz_mode), .carrier_lost(carrier_lost), .bpv_flag(bpv_flag),
    .bpv_count(bpv_count)
  );

  task automatic push(input string tag);
    exp_t e;
    e.nrz = m_nrz; e.nrzm = m_nrzm; e.cl = m_cl; e.bpv = m_bpv; e.cnt = 8'(m_cnt); e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send_bit(input logic p, input logic n, input logic pre,
                          input logic [7:0] pv, input string tag);
    @(negedge clk);
    bit_en = 1'b1; rail_p = p; rail_n = n; preset_en = pre; preset_val = pv;
    m_nrz = p | n;
    m_bpv = 1'b0;
    if (p && n) begin
      m_nrzm = 1'b1; m_ref = 1'b0;
    end else if (p || n) begin
      m_bpv  = m_ref && (m_pol == p);
      m_nrzm = 1'b0; m_ref = 1'b1; m_pol = p;
    end
    if (p || n) begin
      m_zr = 0; m_cl = 1'b0;
    end else begin
      if (m_zr < 32) m_zr++;
      if (m_zr == 32) m_cl = 1'b1;
    end
    if (pre) m_cnt = pv;
    else if (m_bpv && m_cnt < 255) m_cnt++;
    @(negedge clk);
    bit_en = 1'b0; preset_en = 1'b0; rail_p = 1'b1; rail_n = 1'b1;
    push(tag);
    @(negedge clk);
    rail_p = 1'b0; rail_n = 1'b0;
    push({tag, " R2 hold"});
  endtask

  task automatic do_preset(input logic [7:0] pv);
    @(negedge clk);
    preset_en = 1'b1; preset_val = pv;
    m_cnt = pv;
    @(negedge clk);
    preset_en = 1'b0;
    push("R10 preset");
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() > 0);
      #1;
      e = exp_q.pop_front();
      vectors++;
      if (nrz_data !== e.nrz || nrz_mode !== e.nrzm || carrier_lost !== e.cl ||
          bpv_flag !== e.bpv || bpv_count !== e.cnt) begin
        misses++;
        $display("FAIL %s: got nrz=%b mode=%b lost=%b bpv=%b cnt=%0d, expected nrz=%b mode=%b lost=%b bpv=%b cnt=%0d",
                 e.tag, nrz_data, nrz_mode, carrier_lost, bpv_flag, bpv_count,
                 e.nrz, e.nrzm, e.cl, e.bpv, e.cnt);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    push("R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 first mark sets reference; R3 merged data; R6 alternating is clean
    send_bit(1, 0, 0, 0, "R7 first mark");
    send_bit(0, 1, 0, 0, "R3 alt neg");
    send_bit(1, 0, 0, 0, "R6 alt pos");
    send_bit(1, 0, 0, 0, "R6 R8 pos repeat");
    send_bit(0, 0, 0, 0, "R6 flag drops");
    send_bit(0, 1, 0, 0, "R6 neg after pos");
    send_bit(0, 1, 0, 0, "R8 neg repeat");

    // R4 zero run boundary, R5 clear
    for (int i = 0; i < 30; i++) send_bit(0, 0, 0, 0, "R4 zero run");
    send_bit(0, 0, 0, 0, "R4 31st zero");
    send_bit(0, 0, 0, 0, "R4 32nd zero");
    send_bit(0, 0, 0, 0, "R4 stays lost");
    send_bit(1, 0, 0, 0, "R5 mark clears");

    // R11 tied rails
    send_bit(1, 1, 0, 0, "R11 tied mark");
    send_bit(1, 1, 0, 0, "R11 tied again");
    send_bit(0, 0, 0, 0, "R11 tied zero");
    send_bit(1, 0, 0, 0, "R11 R7 leave tied");
    send_bit(1, 0, 0, 0, "R6 after tied");

    // R9 saturation, R10 preset priority
    do_preset(8'd252);
    for (int i = 0; i < 5; i++) send_bit(1, 0, 0, 0, "R9 saturate");
    send_bit(1, 0, 1, 8'd7, "R10 preset beats violation");
    send_bit(1, 0, 0, 0, "R8 after preset");

    repeat (4) @(negedge clk);
    wait (exp_q.size() == 0);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule